// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to `NSRC` peripheral interrupt lines and drives an active-low interrupt request toward a processor. Each line has its own configuration slot: a 3-bit priority, a 2-bit trigger type and a vector word. Software does not address the slots directly. It first writes a source number into a select register, and the mode, vector, enable, disable and clear accesses that follow act on that source only.

The processor collects an interrupt by reading the vector register. The read returns the vector of the winning source and records that source as the one in service. It also pushes the winner's priority onto an eight-deep level stack and acknowledges the source. A write to the end-of-interrupt register pops the stack. A debug protect mode lets a debugger read the vector without disturbing the controller: the push and the acknowledge are held back until software writes the vector register. If a read finds nothing to serve, the controller returns a programmable spurious vector. A key-gated lock keeps the configuration registers from being changed by accident.

Top module: `vpic`

## Requirements
- R1: The mode, vector, enable (address 6), disable (address 7) and clear (address 8) accesses act only on the source whose number was last written to the select register (address 0). A read of address 6 returns that source's enable bit.
- R2: The winner is the enabled pending source with the highest priority (7 is the highest). When priorities are equal, the lower source number wins. `irq_n` is low exactly when a winner exists and its priority is strictly above the top of the level stack, or the stack is empty.
- R3: In normal mode, a read of the vector register (address 3) while `irq_n` is low does four things. It returns the winner's vector, records the winner's number in the status register (address 4), pushes the winner's priority onto the stack and acknowledges the winner.
- R4: With protect mode on (bit 0 of address 10 equal to 1), a vector read returns the vector and remembers the source, but it makes no push, no acknowledge and no status change. A later write of any value to address 3 performs all three for the remembered source.
- R5: In normal mode, a write to address 3 changes nothing.
- R6: A vector read while `irq_n` is high returns the spurious-vector register (address 9). It makes no push and leaves the status register unchanged.
- R7: Any write to address 5 pops one level; on an empty stack it does nothing. The stack holds 8 levels, so eight such writes always empty it.
- R8: The lock register (address 11) accepts a write only when `wdata[31:8]` equals the key. Bit 0 of that write then sets the lock (1) or clears it (0). While the lock is set, writes to the mode, vector, spurious-vector and debug registers are ignored. The lock is set after reset, and address 11 reads back the lock bit.
- R9: The mode register (address 1) holds the priority in bits [2:0] and the trigger type in bits [5:4]. A read returns both fields at the same positions, so software can rewrite one field and keep the other. Trigger codes: 00 level active-high, 01 level active-low, 10 rising edge, 11 falling edge.
- R10: An edge source latches as pending on its active edge. The latch is cleared by its acknowledge or by a clear command. A level source is pending only while its input is active, so a pulse that ends before the vector read gives the spurious result.
- R11: Bit 0 of the core-status register (address 12) reads the present level of `irq_n`.
- R12: After reset all sources are disabled, the stack is empty, `irq_n` is high, the status register reads 0 and the lock is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Interrupt lines, synchronous to `clk` |
| addr | input | 4 | Register word address |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access; side effects occur at the clock edge ending the strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid in the cycle `rd` is high |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The assertions check the stack on every cycle. A normal-mode vector read with a request pending grows it by exactly one, and an end-of-interrupt write shrinks it by exactly one. Spurious reads, protect-mode reads and normal-mode vector writes leave the stack and the status untouched, and a push never overflows the eight levels. The assertions also check that a spurious read returns the spurious register and that a locked spurious register ignores writes. Tie-breaking between equal priorities, edge latching and clearing, nested service with unwinding, the deferred commit in protect mode and the key check need the bench's scenarios. A reference model compares `irq_n` and every read value against the design on each clock.

// File: rtl/vpic.sv
module vpic #(
  parameter int NSRC = 32,
  parameter int DW = 32,
  parameter int DEPTH = 8,
  parameter logic [DW-9:0] KEY = 24'h5A3C96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [3:0]      addr,
  input  logic            wr,
  input  logic            rd,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_n
);
  localparam int IW = $clog2(NSRC);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [3:0] A_SEL = 4'd0, A_MODE = 4'd1, A_VEC = 4'd2, A_IVR = 4'd3,
                         A_STAT = 4'd4, A_EOI = 4'd5, A_ENA = 4'd6, A_DIS = 4'd7,
                         A_CLR = 4'd8, A_SPUR = 4'd9, A_DBG = 4'd10, A_LOCK = 4'd11,
                         A_CORE = 4'd12;

  logic [2:0]      prio [NSRC];
  logic [1:0]      trig [NSRC];
  logic [DW-1:0]   vec  [NSRC];
  logic [NSRC-1:0] en, elat, prev_act, pol, edg, act, cand;
  logic [IW-1:0]   sel, stat, held, win, push_src;
  logic            held_v, prot, locked;
  logic [DW-1:0]   spur;
  logic [2:0]      stk [DEPTH];
  logic [SPW-1:0]  sp;
  logic [2:0]      top, wp, push_lvl;
  logic            win_v, go, ivr_rd, ivr_wr, commit, do_push, pop, clr;
  logic [NSRC-1:0] ackm, clrm;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign pol[g] = trig[g][0];
    assign edg[g] = trig[g][1];
  end

  assign act  = src_in ^ pol;
  assign cand = en & ((edg & elat) | (~edg & act));

  always_comb begin
    win_v = 1'b0;
    win = '0;
    wp = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i] && (!win_v || prio[i] >= wp)) begin
        win_v = 1'b1;
        win = IW'(i);
        wp = prio[i];
      end
  end

  always_comb begin
    top = '0;
    for (int k = 0; k < DEPTH; k++)
      if (sp == SPW'(k + 1)) top = stk[k];
  end

  assign go       = win_v && (sp == '0 || wp > top);
  assign irq_n    = ~go;
  assign ivr_rd   = rd && addr == A_IVR;
  assign ivr_wr   = wr && addr == A_IVR;
  assign commit   = ivr_wr && prot && held_v;
  assign do_push  = (ivr_rd && !prot && go) || commit;
  assign push_src = prot ? held : win;
  assign push_lvl = prot ? prio[held] : wp;
  assign pop      = wr && addr == A_EOI && sp != '0;
  assign clr      = wr && addr == A_CLR;
  assign ackm     = do_push ? (NSRC'(1) << push_src) : '0;
  assign clrm     = clr ? (NSRC'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0;
        trig[i] <= '0;
        vec[i]  <= '0;
      end
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
      en <= '0;
      elat <= '0;
      prev_act <= '0;
      sel <= '0;
      stat <= '0;
      held <= '0;
      held_v <= 1'b0;
      prot <= 1'b0;
      locked <= 1'b1;
      spur <= '0;
      sp <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_SEL:  sel <= wdata[IW-1:0];
          A_MODE: if (!locked) begin
                    prio[sel] <= wdata[2:0];
                    trig[sel] <= wdata[5:4];
                  end
          A_VEC:  if (!locked) vec[sel] <= wdata;
          A_ENA:  en[sel] <= 1'b1;
          A_DIS:  en[sel] <= 1'b0;
          A_SPUR: if (!locked) spur <= wdata;
          A_DBG:  if (!locked) prot <= wdata[0];
          A_LOCK: if (wdata[DW-1:8] == KEY) locked <= wdata[0];
          default: ;
        endcase
      end
      if (ivr_rd && prot) begin
        held <= win;
        held_v <= go;
      end
      if (commit) held_v <= 1'b0;
      if (do_push) stat <= push_src;
      for (int k = 0; k < DEPTH; k++)
        if (do_push && sp == SPW'(k)) stk[k] <= push_lvl;
      if (do_push) sp <= sp + 1'b1;
      else if (pop) sp <= sp - 1'b1;
      elat <= (elat & ~ackm & ~clrm) | (edg & act & ~prev_act);
      prev_act <= act;
    end
  end

  always_comb begin
    case (addr)
      A_SEL:   rdata = DW'(sel);
      A_MODE:  rdata = DW'({trig[sel], 1'b0, prio[sel]});
      A_VEC:   rdata = vec[sel];
      A_IVR:   rdata = go ? vec[win] : spur;
      A_STAT:  rdata = DW'(stat);
      A_ENA:   rdata = DW'(en[sel]);
      A_SPUR:  rdata = spur;
      A_DBG:   rdata = DW'(prot);
      A_LOCK:  rdata = DW'(locked);
      A_CORE:  rdata = DW'(irq_n);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int DEPTH = 8,
  parameter int SPW = 4,
  parameter int IW = 5,
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [3:0]     addr,
  input logic           wr,
  input logic           rd,
  input logic           irq_n,
  input logic [DW-1:0]  rdata,
  input logic [DW-1:0]  spur,
  input logic [SPW-1:0] sp,
  input logic [IW-1:0]  stat,
  input logic           prot,
  input logic           locked,
  input logic           do_push
);
  localparam logic [3:0] C_IVR = 4'd3, C_EOI = 4'd5, C_SPUR = 4'd9;

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> sp < SPW'(DEPTH));
  a_r7_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == C_EOI && sp != '0) |=> sp == $past(sp) - SPW'(1));
  a_r3_push_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == C_IVR && !prot && !irq_n) |=> sp == $past(sp) + SPW'(1));
  a_r6_spur_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == C_IVR && irq_n) |-> rdata == spur);
  a_r6_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == C_IVR && irq_n) |=> $stable(sp) && $stable(stat));
  a_r5_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == C_IVR && !prot) |=> $stable(sp) && $stable(stat));
  a_r4_read_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == C_IVR && prot) |=> $stable(sp) && $stable(stat));
  a_r8_locked_spur: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == C_SPUR && locked) |=> $stable(spur));
endmodule

bind vpic vpic_chk #(.DEPTH(DEPTH), .SPW(SPW), .IW(IW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .irq_n(irq_n),
  .rdata(rdata), .spur(spur), .sp(sp), .stat(stat), .prot(prot),
  .locked(locked), .do_push(do_push)
);

// File: tb/vpic_bench.sv
module vpic_bench;
  localparam int N = 32;
  localparam logic [23:0] KEY = 24'h5A3C96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic [3:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_n;

  always #10 clk = ~clk;

  vpic #(.NSRC(N), .DW(32), .DEPTH(8), .KEY(KEY)) u_vpic (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R12";

  int m_prio[N], m_trig[N];
  logic [31:0] m_vec[N];
  bit m_en[N], m_elat[N], m_prev[N];
  int m_sel, m_stat, m_held;
  bit m_heldv, m_dbg, m_locked;
  logic [31:0] m_spur;
  int m_stk[$];

  function automatic bit m_act(int i);
    return src_in[i] ^ m_trig[i][0];
  endfunction

  function automatic bit m_pend(int i);
    return (m_trig[i] >= 2) ? m_elat[i] : m_act(i);
  endfunction

  function automatic int m_win();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend(i) && (m_stk.size() == 0 || m_prio[i] > m_stk[$]) &&
          (best < 0 || m_prio[i] > m_prio[best]))
        best = i;
    return best;
  endfunction

  function automatic logic [31:0] m_read(int a);
    int w = m_win();
    case (a)
      0: return m_sel;
      1: return (m_trig[m_sel] << 4) | m_prio[m_sel];
      2: return m_vec[m_sel];
      3: return (w < 0) ? m_spur : m_vec[w];
      4: return m_stat;
      6: return {31'd0, m_en[m_sel]};
      9: return m_spur;
      10: return {31'd0, m_dbg};
      11: return {31'd0, m_locked};
      12: return (w < 0) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin
      m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0;
      m_en[i] = 0; m_elat[i] = 0; m_prev[i] = 0;
    end
    m_sel = 0; m_stat = 0; m_held = 0; m_heldv = 0;
    m_dbg = 0; m_locked = 1; m_spur = 0;
    m_stk.delete();
  endfunction

  function automatic void m_step();
    int w = m_win();
    int ack = -1, clr = -1;
    bit a[N], ed[N];
    for (int i = 0; i < N; i++) begin
      a[i] = m_act(i);
      ed[i] = (m_trig[i] >= 2) && a[i] && !m_prev[i];
    end
    if (rd && addr == 3) begin
      if (!m_dbg) begin
        if (w >= 0) begin m_stat = w; m_stk.push_back(m_prio[w]); ack = w; end
      end else begin
        m_held = w; m_heldv = (w >= 0);
      end
    end
    if (wr) begin
      case (addr)
        0: m_sel = wdata % N;
        1: if (!m_locked) begin m_prio[m_sel] = wdata[2:0]; m_trig[m_sel] = wdata[5:4]; end
        2: if (!m_locked) m_vec[m_sel] = wdata;
        3: if (m_dbg && m_heldv) begin
             m_stat = m_held; m_stk.push_back(m_prio[m_held]); ack = m_held; m_heldv = 0;
           end
        5: if (m_stk.size() > 0) void'(m_stk.pop_back());
        6: m_en[m_sel] = 1;
        7: m_en[m_sel] = 0;
        8: clr = m_sel;
        9: if (!m_locked) m_spur = wdata;
        10: if (!m_locked) m_dbg = wdata[0];
        11: if (wdata[31:8] == KEY) m_locked = wdata[0];
        default: ;
      endcase
    end
    for (int i = 0; i < N; i++) begin
      if (i == ack || i == clr) m_elat[i] = 0;
      if (ed[i]) m_elat[i] = 1;
      m_prev[i] = a[i];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      checks++;
      if (irq_n !== (m_win() < 0)) begin
        errors++;
        $display("FAIL %s model irq_n actual %b expected %b", tag, irq_n, m_win() < 0);
      end
      if (rd) begin
        checks++;
        if (rdata !== m_read(addr)) begin
          errors++;
          $display("FAIL %s model read addr %0d actual %h expected %h", tag, addr, rdata, m_read(addr));
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(int a, logic [31:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic br_chk(string req, int a, logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk); addr = 4'(a); rd = 1'b1;
    #5 d = rdata;
    @(negedge clk); rd = 1'b0;
    check(req, d, exp);
  endtask

  task automatic setsrc(int i, bit v);
    @(negedge clk); src_in[i] = v;
  endtask

  task automatic irq_chk(string req, bit exp);
    @(negedge clk); #5;
    check(req, {31'd0, irq_n}, {31'd0, exp});
  endtask

  task automatic cfg(int i, int p, int t, logic [31:0] v);
    bw(0, i); bw(1, (t << 4) | p); bw(2, v); bw(6, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R12 watchdog actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R12";
    br_chk("R12 R11 core irq_n", 12, 1);
    br_chk("R12 status", 4, 0);
    br_chk("R12 lock set", 11, 1);
    br_chk("R12 enable", 6, 0);

    tag = "R8";
    bw(9, 32'h1234);
    br_chk("R8 locked spur", 9, 0);
    bw(11, {KEY, 8'h00});
    br_chk("R8 unlocked", 11, 0);
    bw(11, {24'h111111, 8'h01});
    br_chk("R8 wrong key", 11, 0);
    bw(9, 32'hDEAD0000);
    br_chk("R8 spur written", 9, 32'hDEAD0000);

    tag = "R9";
    src_in[8] = 1'b1;
    cfg(3, 2, 0, 32'h300);
    cfg(5, 2, 2, 32'h500);
    cfg(9, 6, 2, 32'h900);
    br_chk("R9 mode src9", 1, 32'h26);
    bw(0, 5);
    br_chk("R9 mode src5", 1, 32'h22);
    br_chk("R1 enable src5", 6, 1);

    tag = "R3";
    setsrc(3, 1);
    irq_chk("R2 level request", 0);
    br_chk("R3 vector", 3, 32'h300);
    br_chk("R3 status", 4, 3);
    irq_chk("R2 same level masked", 1);
    tag = "R2";
    setsrc(5, 1); setsrc(5, 0);
    irq_chk("R2 equal priority not above", 1);
    bw(5, 0);
    irq_chk("R7 pop reasserts", 0);
    br_chk("R2 tie lower index", 3, 32'h300);
    bw(5, 0);
    tag = "R10";
    setsrc(3, 0);
    br_chk("R10 edge latched", 3, 32'h500);
    bw(5, 0);
    irq_chk("R10 ack clears latch", 1);

    tag = "R7";
    setsrc(3, 1);
    br_chk("R7 outer", 3, 32'h300);
    setsrc(9, 1); setsrc(9, 0);
    irq_chk("R2 higher nests", 0);
    br_chk("R7 inner", 3, 32'h900);
    br_chk("R3 status nested", 4, 9);
    irq_chk("R2 top level masks", 1);
    bw(5, 0);
    irq_chk("R7 back to outer", 1);
    bw(5, 0);
    irq_chk("R7 empty stack", 0);
    setsrc(3, 0);
    irq_chk("R10 level dropped", 1);
    bw(5, 0);

    tag = "R6";
    setsrc(3, 1); setsrc(3, 0);
    br_chk("R6 spurious vector", 3, 32'hDEAD0000);
    br_chk("R6 status kept", 4, 9);
    setsrc(5, 1); setsrc(5, 0);
    irq_chk("R6 no push", 0);
    br_chk("R6 after spurious", 3, 32'h500);
    bw(5, 0);

    tag = "R4";
    bw(10, 1);
    setsrc(3, 1);
    br_chk("R4 protect vector", 3, 32'h300);
    br_chk("R4 status deferred", 4, 5);
    irq_chk("R4 no push on read", 0);
    bw(3, 0);
    br_chk("R4 commit status", 4, 3);
    irq_chk("R4 commit pushed", 1);
    bw(5, 0);
    bw(10, 0);
    tag = "R5";
    bw(3, 0);
    irq_chk("R5 write inert", 0);
    setsrc(3, 0);

    tag = "R1";
    bw(0, 4); bw(1, 32'h07);
    bw(0, 3);
    br_chk("R1 mode other slot", 1, 32'h02);
    bw(0, 4);
    br_chk("R1 enable slot4", 6, 0);
    br_chk("R1 mode slot4", 1, 32'h07);
    bw(0, 3); bw(7, 0);
    setsrc(3, 1);
    irq_chk("R1 disabled source", 1);
    bw(6, 0);
    irq_chk("R1 re-enabled", 0);
    br_chk("R1 vector", 3, 32'h300);
    bw(5, 0);
    setsrc(3, 0);

    tag = "R10";
    setsrc(5, 1); setsrc(5, 0);
    bw(8, 0);
    irq_chk("R1 clear wrong slot", 0);
    bw(0, 5); bw(8, 0);
    irq_chk("R10 clear command", 1);

    tag = "R9";
    cfg(7, 1, 1, 32'h700);
    irq_chk("R9 level low active", 0);
    br_chk("R9 level low vector", 3, 32'h700);
    bw(5, 0);
    setsrc(7, 1);
    irq_chk("R9 level low idle", 1);
    cfg(8, 1, 3, 32'h800);
    irq_chk("R9 falling idle", 1);
    setsrc(8, 0);
    irq_chk("R9 falling edge", 0);
    br_chk("R9 falling vector", 3, 32'h800);
    bw(5, 0);
    irq_chk("R9 falling acked", 1);

    tag = "R7";
    for (int k = 0; k < 8; k++) cfg(10 + k, k, 2, 32'h1000 + k);
    for (int k = 0; k < 8; k++) begin
      setsrc(10 + k, 1); setsrc(10 + k, 0);
      br_chk("R7 nest level", 3, 32'h1000 + k);
    end
    setsrc(17, 1); setsrc(17, 0);
    irq_chk("R7 full stack masks", 1);
    for (int k = 0; k < 8; k++) bw(5, 0);
    irq_chk("R7 eight pops empty", 0);
    br_chk("R7 after unwind", 3, 32'h1007);
    bw(5, 0);
    bw(5, 0);
    irq_chk("R7 pop on empty", 1);

    tag = "R8";
    bw(11, {KEY, 8'h01});
    bw(0, 10); bw(1, 32'h27);
    br_chk("R8 locked mode", 1, 32'h20);
    bw(2, 1);
    br_chk("R8 locked vector", 2, 32'h1000);
    bw(10, 1);
    br_chk("R8 locked debug", 10, 0);
    br_chk("R11 core idle", 12, 1);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end
endmodule